// File: doc/BRIEF.md
# Memory Attribute Region Table

This block keeps a small table of physical address windows, each tagged with one of eight memory-type classes. The load/store path presents an address on the lookup port. One cycle later the block returns the class of the window that covers it, together with a hit flag and the index of the winning entry. It also returns two convenience bits: whether the access may be cached, and whether writes may be buffered. The load/store path uses these to choose cacheability, write buffering and line allocation. Device windows and non-cacheable windows always report the address as uncached, so buffers shared with DMA masters that sit in them never go through the cache.

Software or a configuration sequencer programs the table at run time through a write port. Each write selects one entry by index. A write either installs a window or retires the entry. A window must be a power of two in size, at least 4 KiB, and its start must be a multiple of its size. A write that breaks these rules is refused, and the refusal is signalled for one cycle.

Top module: `mem_attr_table`

## Requirements
- R1: A lookup presented with `lkEn` high at a clock edge produces `resValid` high exactly one cycle later, together with its result. `resValid` is low in every cycle that follows an edge with `lkEn` low. One lookup can be accepted every cycle.
- R2: An address A hits a valid entry with start S and size Z when S <= A < S+Z. On a hit, `resHit` is 1 and `resClass` and `resIdx` come from that entry. A = S+Z does not hit that entry.
- R3: An address that hits no valid entry returns `resHit` = 0 and `resClass` = 3'b111, which is write-back with read and write allocate.
- R4: When several valid entries cover the address, the entry with the lowest index wins.
- R5: The class codes are as follows.
  - 000: device, not bufferable.
  - 001: device, bufferable.
  - 100: memory, uncached, not bufferable.
  - 101: memory, uncached, bufferable.
  - 010: write-back, no allocate.
  - 011: write-back, read allocate.
  - 110: write-back, write allocate.
  - 111: write-back, read and write allocate.

  `resCacheable` is 1 only for the four write-back codes. `resBufferable` is 0 only for 000 and 100.
- R6: A write with `wrActive` = 1 is refused in the following cases:
  - `wrSize` is not a power of two.
  - `wrSize` is below 4096.
  - `wrBase` is not a multiple of `wrSize`.

  A refused write pulses `wrReject` high in the next cycle and leaves the entry unchanged.
- R7: A write with `wrActive` = 0 always succeeds, whatever `wrBase` and `wrSize` hold. It marks the entry invalid, and an invalid entry never matches.
- R8: A write takes effect at its clock edge. A lookup sampled at that same edge still sees the old table. Lookups from the next edge onward see the new entry.
- R9: After reset every entry is invalid, and `resValid` and `wrReject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one table entry |
| wrIdx | input | 4 | Index of the entry to write |
| wrActive | input | 1 | 1 installs a window, 0 retires the entry |
| wrBase | input | 32 | Window start address |
| wrSize | input | 32 | Window size in bytes |
| wrClass | input | 3 | Class code for the window |
| wrReject | output | 1 | One-cycle pulse: the previous write was refused |
| lkEn | input | 1 | Lookup request |
| lkAddr | input | 32 | Physical address to classify |
| resValid | output | 1 | Lookup result is present |
| resHit | output | 1 | Address fell in a valid entry |
| resIdx | output | 4 | Index of the winning entry (0 on a miss) |
| resClass | output | 3 | Class code of the result |
| resCacheable | output | 1 | Address may be held in the cache |
| resBufferable | output | 1 | Writes to the address may be buffered |

## Verification
The in-design assertions check the following on every cycle:
- the one-cycle lookup timing;
- the default class on a miss;
- that entries do not change without a commit strobe;
- that a retire write invalidates its entry;
- that device classes are never reported cacheable;
- that a reject pulse always follows a write.

The following can only be shown by the bench's scenarios, run against its behavioural model:
- correct window bounds, including the first address past a window;
- lowest-index priority among overlapping windows;
- refusal of each kind of malformed window with the old entry preserved;
- that a write is not visible to a lookup sampled at the same edge;
- the full class-to-attribute mapping.

// File: rtl/mem_attr_pkg.sv
package mem_attr_pkg;

  localparam int MAX_REGIONS = 16;
  localparam int IDX_W       = 4;

  typedef enum logic [2:0] {
    ATTR_DEV_NB     = 3'b000,
    ATTR_DEV_BUF    = 3'b001,
    ATTR_WB_NOALLOC = 3'b010,
    ATTR_WB_RDALLOC = 3'b011,
    ATTR_MEM_NC_NB  = 3'b100,
    ATTR_MEM_NC_BUF = 3'b101,
    ATTR_WB_WRALLOC = 3'b110,
    ATTR_WB_RWALLOC = 3'b111
  } attrClass_e;

  // Control-to-datapath strobes for a single table update
  typedef struct packed {
    logic             commit;
    logic             setValid;
    logic [IDX_W-1:0] idx;
  } tableStrobe_t;

  // Write-back codes have bit 1 set
  function automatic logic attrCacheable(input logic [2:0] cls);
    return cls[1];
  endfunction

  // Write-back codes buffer; elsewhere bit 0 is the buffer flag
  function automatic logic attrBufferable(input logic [2:0] cls);
    return cls[1] | cls[0];
  endfunction

endpackage

// File: rtl/mem_attr_ctrl.sv
module mem_attr_ctrl
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_REGIONS   = 16,
  parameter int MIN_SIZE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrActive,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrSize,
  output tableStrobe_t      strobe,
  output logic              wrReject
);

  localparam logic [IDX_W:0] IDX_LIMIT = NUM_REGIONS[IDX_W:0];

  logic sizePow2;
  logic sizeBigEnough;
  logic baseAligned;
  logic idxInRange;
  logic writeAccepted;
  logic rejectQ;

  assign sizePow2      = (wrSize != '0) && ((wrSize & (wrSize - 1'b1)) == '0);
  assign sizeBigEnough = |(wrSize >> MIN_SIZE_LOG2);
  assign baseAligned   = (wrBase & (wrSize - 1'b1)) == '0;
  assign idxInRange    = {1'b0, wrIdx} < IDX_LIMIT;

  assign writeAccepted = wrEn && idxInRange &&
                         (!wrActive || (sizePow2 && sizeBigEnough && baseAligned));

  always_comb begin
    strobe          = '0;
    strobe.commit   = writeAccepted;
    strobe.setValid = wrActive;
    strobe.idx      = wrIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rejectQ <= 1'b0;
    else       rejectQ <= wrEn && !writeAccepted;
  end

  assign wrReject = rejectQ;

  // R6: a reject pulse only ever follows a write request
  assert_reject_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> $past(wrEn));

  // R7: a retire request is never refused for its base or size
  assert_retire_accepted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrActive && idxInRange) |=> !wrReject);

endmodule

// File: rtl/mem_attr_datapath.sv
module mem_attr_datapath
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tableStrobe_t      strobe,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrSize,
  input  logic [2:0]        wrClass,
  input  logic              lkEn,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              resValid,
  output logic              resHit,
  output logic [IDX_W-1:0]  resIdx,
  output logic [2:0]        resClass
);

  logic [NUM_REGIONS-1:0]             validQ;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] baseQ;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] maskQ;
  logic [NUM_REGIONS-1:0][2:0]        classQ;
  logic [NUM_REGIONS-1:0]             matchVec;

  logic             anyMatch;
  logic [IDX_W-1:0] selIdx;
  logic [2:0]       selClass;

  logic             resValidQ;
  logic             resHitQ;
  logic [IDX_W-1:0] resIdxQ;
  logic [2:0]       resClassQ;

  // Per-entry storage and address comparator
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        baseQ[g]  <= '0;
        maskQ[g]  <= '0;
        classQ[g] <= ATTR_WB_RWALLOC;
      end else if (strobe.commit && (strobe.idx == IDX_W'(g))) begin
        validQ[g] <= strobe.setValid;
        if (strobe.setValid) begin
          baseQ[g]  <= wrBase;
          maskQ[g]  <= ~(wrSize - 1'b1);
          classQ[g] <= wrClass;
        end
      end
    end

    assign matchVec[g] = validQ[g] && ((lkAddr & maskQ[g]) == baseQ[g]);
  end

  // Lowest-index winner: scan downwards so the smallest match lands last
  always_comb begin
    selIdx   = '0;
    selClass = ATTR_WB_RWALLOC;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        selIdx   = i[IDX_W-1:0];
        selClass = classQ[i];
      end
    end
  end

  assign anyMatch = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValidQ <= 1'b0;
      resHitQ   <= 1'b0;
      resIdxQ   <= '0;
      resClassQ <= ATTR_WB_RWALLOC;
    end else begin
      resValidQ <= lkEn;
      if (lkEn) begin
        resHitQ   <= anyMatch;
        resIdxQ   <= selIdx;
        resClassQ <= selClass;
      end
    end
  end

  assign resValid = resValidQ;
  assign resHit   = resHitQ;
  assign resIdx   = resIdxQ;
  assign resClass = resClassQ;

  // R1: result appears exactly one cycle after a request
  assert_result_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    lkEn |=> resValid);
  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lkEn |=> !resValid);

  // R3: a miss carries the default write-back allocate class
  assert_miss_default_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resClass == 3'b111));

  // R7: an empty table cannot produce a hit
  assert_empty_no_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkEn && (validQ == '0)) |=> !resHit);

  // R7: a committed retire write clears its entry
  assert_retire_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.setValid) |=> !validQ[$past(strobe.idx)]);

  // R6: without a commit strobe the table holds its contents
  assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(validQ) && $stable(baseQ) && $stable(maskQ) && $stable(classQ)));

endmodule

// File: rtl/mem_attr_table.sv
module mem_attr_table
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_REGIONS   = 16,
  parameter int MIN_SIZE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic              wrActive,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrSize,
  input  logic [2:0]        wrClass,
  output logic              wrReject,
  input  logic              lkEn,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              resValid,
  output logic              resHit,
  output logic [3:0]        resIdx,
  output logic [2:0]        resClass,
  output logic              resCacheable,
  output logic              resBufferable
);

  if (NUM_REGIONS < 1 || NUM_REGIONS > MAX_REGIONS) begin : g_bad_count
    $error("mem_attr_table: NUM_REGIONS must lie between 1 and 16");
  end

  tableStrobe_t strobe;

  mem_attr_ctrl #(
    .ADDR_W        (ADDR_W),
    .NUM_REGIONS   (NUM_REGIONS),
    .MIN_SIZE_LOG2 (MIN_SIZE_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrActive (wrActive),
    .wrBase   (wrBase),
    .wrSize   (wrSize),
    .strobe   (strobe),
    .wrReject (wrReject)
  );

  mem_attr_datapath #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrBase   (wrBase),
    .wrSize   (wrSize),
    .wrClass  (wrClass),
    .lkEn     (lkEn),
    .lkAddr   (lkAddr),
    .resValid (resValid),
    .resHit   (resHit),
    .resIdx   (resIdx),
    .resClass (resClass)
  );

  assign resCacheable  = attrCacheable(resClass);
  assign resBufferable = attrBufferable(resClass);

  // R5: device and uncached classes never report cacheable
  assert_uncached_classes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resClass[1]) |-> !resCacheable);

endmodule

// File: tb/mem_attr_table_bench.sv
module mem_attr_table_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrIdx;
  logic        wrActive;
  logic [31:0] wrBase;
  logic [31:0] wrSize;
  logic [2:0]  wrClass;
  logic        wrReject;
  logic        lkEn;
  logic [31:0] lkAddr;
  logic        resValid;
  logic        resHit;
  logic [3:0]  resIdx;
  logic [2:0]  resClass;
  logic        resCacheable;
  logic        resBufferable;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model of the table
  longint mBase  [16];
  longint mSize  [16];
  bit     mValid [16];
  int     mClass [16];

  always #5 clk = ~clk;

  mem_attr_table u_mem_attr_table (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrActive(wrActive),
    .wrBase(wrBase), .wrSize(wrSize), .wrClass(wrClass), .wrReject(wrReject),
    .lkEn(lkEn), .lkAddr(lkAddr), .resValid(resValid), .resHit(resHit),
    .resIdx(resIdx), .resClass(resClass), .resCacheable(resCacheable),
    .resBufferable(resBufferable)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit expCacheable(int c);
    case (c)
      2, 3, 6, 7: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic bit expBufferable(int c);
    return !(c == 0 || c == 4);
  endfunction

  function automatic bit goodWindow(longint b, longint s);
    longint p = 4096;
    while (p < s) p = p * 2;
    return (p == s) && ((b % s) == 0);
  endfunction

  task automatic idle();
    wrEn = 0; wrIdx = 0; wrActive = 0; wrBase = 0; wrSize = 0; wrClass = 0;
    lkEn = 0; lkAddr = 0;
  endtask

  // One clock: predict from current inputs and model, advance, compare
  task automatic tick(string tag);
    bit     eValid = lkEn;
    bit     eHit   = 0;
    int     eIdx   = 0;
    int     eCls   = 7;
    bit     eRej   = 0;
    longint a      = longint'(lkAddr);
    for (int i = 0; i < 16; i++) begin
      if (!eHit && mValid[i] && a >= mBase[i] && a < mBase[i] + mSize[i]) begin
        eHit = 1; eIdx = i; eCls = mClass[i];
      end
    end
    if (wrEn) begin
      if (!wrActive) begin
        mValid[wrIdx] = 0;
      end else if (goodWindow(longint'(wrBase), longint'(wrSize))) begin
        mValid[wrIdx] = 1;
        mBase[wrIdx]  = longint'(wrBase);
        mSize[wrIdx]  = longint'(wrSize);
        mClass[wrIdx] = int'(wrClass);
      end else begin
        eRej = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "resValid", resValid, eValid);
    chk(tag, "wrReject", wrReject, eRej);
    if (eValid) begin
      chk(tag, "resHit", resHit, eHit);
      chk(tag, "resClass", resClass, eCls);
      chk(tag, "resCacheable", resCacheable, expCacheable(eCls));
      chk(tag, "resBufferable", resBufferable, expBufferable(eCls));
      if (eHit) chk(tag, "resIdx", resIdx, eIdx);
    end
  endtask

  task automatic doWrite(int idx, bit act, longint b, longint s, int c, string tag);
    idle();
    wrEn = 1; wrIdx = 4'(idx); wrActive = act;
    wrBase = 32'(b); wrSize = 32'(s); wrClass = 3'(c);
    tick(tag);
    idle();
  endtask

  task automatic doLook(longint addr, string tag);
    idle();
    lkEn = 1; lkAddr = 32'(addr);
    tick(tag);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mBase[i] = 0; mSize[i] = 0; mClass[i] = 7;
    end
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "resValid in reset", resValid, 0);
    chk("R9", "wrReject in reset", wrReject, 0);
    rstN = 1;

    // R9 / R3: empty table misses with default class
    doLook(64'h8000_0000, "R9");
    doLook(64'h0, "R3");
    tick("R1");   // no request -> no result

    // R8: lookup in the same cycle as the write still misses
    idle();
    wrEn = 1; wrIdx = 3; wrActive = 1; wrBase = 32'h8000_0000;
    wrSize = 32'h1000_0000; wrClass = 3'b001;
    lkEn = 1; lkAddr = 32'h8000_0040;
    tick("R8");
    idle();
    doLook(64'h8000_0040, "R8");

    // R2: window bounds
    doLook(64'h8FFF_FFFF, "R2");
    doLook(64'h9000_0000, "R2");
    doLook(64'h7FFF_FFFF, "R2");

    // R4: overlapping smaller window at lower index wins
    doWrite(1, 1, 64'h8000_0000, 64'h1000, 4, "R4");
    doLook(64'h8000_0010, "R4");
    doLook(64'h8000_2000, "R4");
    doWrite(9, 1, 64'h8000_0000, 64'h1000, 6, "R4");
    doLook(64'h8000_0FFF, "R4");

    // R6: refused windows leave the entry intact
    doWrite(1, 1, 64'h8000_0000, 64'h3000, 2, "R6");
    doWrite(1, 1, 64'h8000_0000, 64'h800, 2, "R6");
    doWrite(1, 1, 64'h8000_1000, 64'h2000, 2, "R6");
    doWrite(1, 1, 64'h8000_0000, 64'h0, 2, "R6");
    doLook(64'h8000_0010, "R6");

    // R7: retire with garbage base/size, then lower-priority entry shows
    doWrite(1, 0, 64'h1234_5678, 64'h3, 0, "R7");
    doLook(64'h8000_0010, "R7");
    doWrite(9, 0, 64'h0, 64'h0, 0, "R7");
    doLook(64'h8000_0010, "R7");

    // R5: each class code and its derived attributes
    for (int c = 0; c < 8; c++) begin
      doWrite(0, 1, 64'h4000_0000, 64'h1_0000, c, "R5");
      doLook(64'h4000_8000, "R5");
    end

    // R1: back-to-back lookups, one per cycle
    idle();
    for (int k = 0; k < 6; k++) begin
      lkEn = 1;
      lkAddr = (k % 2 == 0) ? 32'h4000_0100 : 32'h8800_0000;
      tick("R1");
    end
    idle();

    // R2 / R4 / R6: mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      longint sz = longint'(1) << (10 + ($urandom % 12));
      longint bs = longint'($urandom & 32'h00FF_FFFF) & ~(sz - 1);
      if (($urandom % 8) == 0) bs = bs + 64'h800;
      wrEn     = ($urandom % 4) == 0;
      wrIdx    = 4'($urandom);
      wrActive = ($urandom % 5) != 0;
      wrBase   = 32'(bs);
      wrSize   = 32'(sz);
      wrClass  = 3'($urandom);
      lkEn     = ($urandom % 5) != 0;
      lkAddr   = $urandom & 32'h00FF_FFFF;
      tick("R2");
    end
    idle();
    tick("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule